// File: doc/BRIEF.md
# DRAM Page-Hit and Bus-Sizing Sequencer

This block sits between an on-chip transfer engine and an external DRAM-style memory port. It takes one byte-addressed transfer request at a time, of 1, 2, 4 or 8 bytes aligned to its own size. It turns the request into a sequence of row and column cycles on the memory side. A row cycle drives the full 32-bit address and a 6-bit cycle-type status. In the same cycle the block samples four strap inputs: page size, column shift, bus width and column timing. Column cycles drive a multiplexed column address, byte strobes and write data steered onto the lanes that the selected bus width and byte order use.

The block keeps the page address of the last access together with a valid flag. For each new request it compares the enabled upper address bits against that stored page. A match goes straight to column cycles, and a mismatch opens a new row. A transfer wider than the memory bus is split into several column accesses at rising addresses. With page mode turned off, each of those accesses gets its own row cycle.

Top module: `dram_page_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_row` and `mem_col` are 0, `mem_status` is 011111, and `mem_addr`, `mem_be` and `mem_wdata` are all zero.
- R2: The first request after reset always starts with a row cycle, because the stored page is invalid. A row cycle lasts one cycle and drives the full beat address. Its status is 000000 for a read and 000001 for a write. Every cycle that is not a row cycle shows status 011111.
- R3: A request whose address matches the stored page on the compared bits goes straight to column cycles, with no row cycle. The compared bits are set by the page-size code latched at the last row cycle. Code c in 0..4 compares A[31:6+c]. Code c in 5..7 compares A[31:13+c]. Code c in 9..15 compares A[31:c+2].
- R4: A mismatch on any compared bit opens the request with a row cycle. That row cycle stores the new page.
- R5: Page-size code 1000 turns page mode off. Every request opens with a row cycle, and every further column access of a split transfer is preceded by its own row cycle.
- R6: The column address is the beat address shifted right by 7+s bits for shift code s in 1..7, with bits [2:0] cleared and then replaced by the beat address bits [2:0]. Shift code 0 leaves the address unchanged.
- R7: Bus-width code b (00, 01, 10, 11 = 1, 2, 4, 8 bytes) splits a transfer of N bytes into max(1, N/2^b) column accesses. Access k uses beat address base + k·2^b.
- R8: In little-endian mode (`big_endian`=0), the byte at beat offset o within the bus word goes on lane o, that is `mem_wdata[8o+7:8o]` and `mem_be[o]`. Only bytes that belong to the transfer are strobed. Write-data byte j of the request is the byte at address base+j. Read cycles drive zero data.
- R9: In big-endian mode, bus offset o maps to lane 7−o. A narrow bus therefore uses the top lanes: D[63:56] for 8 bits, D[63:48] for 16 bits and D[63:32] for 32 bits.
- R10: Each column access lasts 2 cycles for timing code 110, 3 cycles for 111 and 1 cycle for any other code. `mem_col` stays high for all of those cycles.
- R11: The straps are sampled only at the row cycle that opens a transfer. Strap changes before a page-hit request, or during the re-row cycles of R5, have no effect on shift, width or timing.
- R12: `req_ready` is low from the cycle after acceptance until the last column cycle ends. A `req_valid` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_addr | input | 32 | Byte start address, aligned to the size |
| req_size | input | 2 | log2 of the byte count (0..3) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write bytes, byte j at bits 8j+7:8j |
| big_endian | input | 1 | Lane order select, held during a transfer |
| strap_page | input | 4 | Page-size code |
| strap_shift | input | 3 | Column shift code |
| strap_bus | input | 2 | Bus width code |
| strap_timing | input | 3 | Column timing code |
| mem_row | output | 1 | Row cycle in progress |
| mem_col | output | 1 | Column access cycle in progress |
| mem_addr | output | 32 | Row address or column address |
| mem_status | output | 6 | Cycle-type status |
| mem_be | output | 8 | Byte-lane strobes |
| mem_wdata | output | 64 | Lane-steered write data |

## Verification
The bench builds the block with its default parameters: 32 address bits, 64 data bits, a 22-bit stored page and compare tags starting at bit 6. With 8 lanes, an 8-byte transfer on a byte-wide bus reaches the longest split of eight accesses. It also brings the 3-cycle timing and the page-off mode within reach, where one request makes 8 rows and 24 column cycles. With the full 32-bit address, the widest page masks (up to A[31:20]) and the largest column shift of 14 bits act on real upper bits. Random requests draw from a few nearby page bases, so hits and misses both occur often.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2
    } seq_st_e;

    localparam logic [5:0] STAT_RD   = 6'b000000;
    localparam logic [5:0] STAT_WR   = 6'b000001;
    localparam logic [5:0] STAT_IDLE = 6'b011111;
    localparam logic [3:0] PS_OFF    = 4'b1000;

    // lowest compared address bit for a page-size code
    function automatic logic [4:0] page_lsb(input logic [3:0] code);
        logic [4:0] r;
        if (code < 4'd5)       r = 5'd6 + {1'b0, code};
        else if (code < 4'd8)  r = 5'd13 + {1'b0, code};
        else if (code == 4'd8) r = 5'd0;
        else                   r = {1'b0, code} + 5'd2;
        return r;
    endfunction

    function automatic logic [4:0] col_shift(input logic [2:0] code);
        return (code == 3'd0) ? 5'd0 : 5'd7 + {2'b00, code};
    endfunction

    function automatic logic [1:0] col_len(input logic [2:0] code);
        logic [1:0] r;
        case (code)
            3'b110:  r = 2'd2;
            3'b111:  r = 2'd3;
            default: r = 2'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dps_page_match.sv
module dps_page_match
    import dps_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int TAG_LSB = 6
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-TAG_LSB-1:0] tag,
    input  logic                      tag_vld,
    input  logic [3:0]                ps_code,
    output logic                      hit
);
    localparam int TW = ADDR_W - TAG_LSB;

    logic [TW-1:0] diff;
    logic [TW-1:0] masked;
    logic [4:0]    sh;

    always_comb begin
        diff   = addr[ADDR_W-1:TAG_LSB] ^ tag;
        sh     = page_lsb(ps_code) - 5'(TAG_LSB);
        masked = diff >> sh;
        hit    = tag_vld && (ps_code != PS_OFF) && (masked == '0);
    end
endmodule

// File: rtl/dps_col_mux.sv
module dps_col_mux
    import dps_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KEEP_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        shift_code,
    output logic [ADDR_W-1:0] col_addr
);
    localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'((1 << KEEP_W) - 1);

    logic [ADDR_W-1:0] shifted;

    always_comb begin
        shifted  = addr >> col_shift(shift_code);
        col_addr = (shifted & ~KEEP_MASK) | (addr & KEEP_MASK);
    end
endmodule

// File: rtl/dps_lane_steer.sv
module dps_lane_steer #(
    parameter int LANES = 8
) (
    input  logic [$clog2(LANES)-1:0] beat_lo,
    input  logic [1:0]               req_size,
    input  logic [1:0]               bus_code,
    input  logic                     big,
    input  logic                     wr,
    input  logic                     en,
    input  logic [8*LANES-1:0]       wdata,
    output logic [LANES-1:0]         be,
    output logic [8*LANES-1:0]       wdata_out
);
    localparam int LAW = $clog2(LANES);

    logic [LAW:0]   bus_n;
    logic [LAW:0]   req_n;
    logic [LAW:0]   beat_n;
    logic [LAW-1:0] bus_base;

    always_comb begin
        bus_n    = (LAW+1)'(1) << bus_code;
        req_n    = (LAW+1)'(1) << req_size;
        beat_n   = (req_size < bus_code) ? req_n : bus_n;
        bus_base = beat_lo & ~LAW'(bus_n - 1'b1);
    end

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [LAW-1:0] off;
        logic [LAW-1:0] ra;
        logic [LAW-1:0] src;
        logic           live;
        always_comb begin
            off  = big ? LAW'(LANES - 1 - L) : LAW'(L);
            ra   = bus_base | off;
            src  = ra & LAW'(req_n - 1'b1);
            live = en && ({1'b0, off} < bus_n) && (ra >= beat_lo) &&
                   ({1'b0, ra} < ({1'b0, beat_lo} + beat_n));
            be[L] = live;
            wdata_out[8*L +: 8] = (live && wr) ? wdata[8*src +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
    import dps_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int PAGE_W  = 22,
    parameter int TAG_LSB = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                big_endian,
    input  logic [3:0]          strap_page,
    input  logic [2:0]          strap_shift,
    input  logic [1:0]          strap_bus,
    input  logic [2:0]          strap_timing,
    output logic                mem_row,
    output logic                mem_col,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [5:0]          mem_status,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int LAW   = $clog2(LANES);
    localparam int LO_W  = ADDR_W - PAGE_W - TAG_LSB;
    localparam int BT_W  = LAW;

    typedef struct packed {
        seq_st_e            st;
        logic [ADDR_W-1:0]  base;
        logic [1:0]         size;
        logic               wr;
        logic [DATA_W-1:0]  wdata;
        logic [BT_W-1:0]    beat;
        logic [1:0]         cnt;
        logic [PAGE_W-1:0]  page;
        logic [LO_W-1:0]    lo;
        logic               vld;
        logic [3:0]         ps;
        logic [2:0]         sh;
        logic [1:0]         bw;
        logic [2:0]         ct;
    } seq_t;

    seq_t q, d;

    logic [ADDR_W-1:0] beat_addr;
    logic [ADDR_W-1:0] col_addr;
    logic [BT_W-1:0]   last_beat;
    logic [1:0]        ncyc;
    logic              page_hit;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] lane_data;

    always_comb begin
        beat_addr = q.base + (ADDR_W'(q.beat) << q.bw);
        last_beat = (q.size > q.bw) ? BT_W'(((LAW+1)'(1) << (q.size - q.bw)) - 1'b1) : '0;
        ncyc      = col_len(q.ct);
    end

    dps_page_match #(.ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB)) u_match (
        .addr    (req_addr),
        .tag     ({q.page, q.lo}),
        .tag_vld (q.vld),
        .ps_code (q.ps),
        .hit     (page_hit)
    );

    dps_col_mux #(.ADDR_W(ADDR_W), .KEEP_W(3)) u_cmux (
        .addr       (beat_addr),
        .shift_code (q.sh),
        .col_addr   (col_addr)
    );

    dps_lane_steer #(.LANES(LANES)) u_lanes (
        .beat_lo   (beat_addr[LAW-1:0]),
        .req_size  (q.size),
        .bus_code  (q.bw),
        .big       (big_endian),
        .wr        (q.wr),
        .en        (q.st == ST_COL),
        .wdata     (q.wdata),
        .be        (lane_be),
        .wdata_out (lane_data)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.base  = req_addr;
                    d.size  = req_size;
                    d.wr    = req_write;
                    d.wdata = req_wdata;
                    d.beat  = '0;
                    d.cnt   = '0;
                    d.st    = page_hit ? ST_COL : ST_ROW;
                end
            end
            ST_ROW: begin
                if (q.beat == '0) begin
                    d.ps = strap_page;
                    d.sh = strap_shift;
                    d.bw = strap_bus;
                    d.ct = strap_timing;
                end
                d.vld  = 1'b1;
                d.page = beat_addr[ADDR_W-1 -: PAGE_W];
                d.lo   = beat_addr[ADDR_W-PAGE_W-1:TAG_LSB];
                d.cnt  = '0;
                d.st   = ST_COL;
            end
            ST_COL: begin
                if (q.cnt == 2'(ncyc - 2'd1)) begin
                    d.cnt = '0;
                    if (q.beat == last_beat) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.beat = q.beat + 1'b1;
                        d.st   = (q.ps == PS_OFF) ? ST_ROW : ST_COL;
                    end
                end else begin
                    d.cnt = q.cnt + 2'd1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        req_ready  = (q.st == ST_IDLE);
        mem_row    = (q.st == ST_ROW);
        mem_col    = (q.st == ST_COL);
        mem_addr   = mem_row ? beat_addr : (mem_col ? col_addr : '0);
        mem_status = mem_row ? (q.wr ? STAT_WR : STAT_RD) : STAT_IDLE;
        mem_be     = lane_be;
        mem_wdata  = lane_data;
    end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_row,
    input logic             mem_col,
    input logic [5:0]       mem_status,
    input logic [LANES-1:0] mem_be
);
    p_row_col_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_row && mem_col));

    p_row_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_row |-> (mem_status == 6'b000000 || mem_status == 6'b000001));

    p_idle_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_row |-> mem_status == 6'b011111);

    p_be_only_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_col |-> mem_be == '0);

    p_col_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_col |-> mem_be != '0);

    p_ready_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_row && !mem_col));
endmodule

bind dram_page_seq dps_checker #(.LANES(DATA_W/8)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_row    (mem_row),
    .mem_col    (mem_col),
    .mem_status (mem_status),
    .mem_be     (mem_be)
);

// File: tb/dram_page_seq_bench.sv
module dram_page_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        big_endian = 1'b0;
    logic [3:0]  strap_page = '0;
    logic [2:0]  strap_shift = '0;
    logic [1:0]  strap_bus = 2'd3;
    logic [2:0]  strap_timing = 3'd4;
    logic        mem_row, mem_col;
    logic [31:0] mem_addr;
    logic [5:0]  mem_status;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;

    always #2 clk = ~clk;

    dram_page_seq u_dram_page_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .big_endian(big_endian), .strap_page(strap_page),
        .strap_shift(strap_shift), .strap_bus(strap_bus), .strap_timing(strap_timing),
        .mem_row(mem_row), .mem_col(mem_col), .mem_addr(mem_addr),
        .mem_status(mem_status), .mem_be(mem_be), .mem_wdata(mem_wdata)
    );

    int total = 0;
    int bad = 0;
    int g_rows, g_cols;

    // reference model state
    bit          m_vld = 0;
    logic [25:0] m_tag = '0;
    logic [3:0]  m_ps = '0;
    logic [2:0]  m_sh = '0;
    logic [1:0]  m_bw = '0;
    logic [2:0]  m_ct = '0;

    bit          e_row [0:63];
    bit          e_col [0:63];
    logic [31:0] e_addr[0:63];
    logic [5:0]  e_stat[0:63];
    logic [7:0]  e_be  [0:63];
    logic [63:0] e_dat [0:63];
    int          n_e;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int m_lsb(input logic [3:0] ps);
        if (ps < 5) return 6 + ps;
        if (ps < 8) return 13 + ps;
        return ps + 2;
    endfunction

    function automatic logic [31:0] m_colmap(input logic [31:0] a, input logic [2:0] s);
        logic [31:0] t;
        if (s == 0) return a;
        t = a >> (7 + s);
        return {t[31:3], a[2:0]};
    endfunction

    function automatic int m_cyc(input logic [2:0] ct);
        if (ct == 3'b110) return 2;
        if (ct == 3'b111) return 3;
        return 1;
    endfunction

    task automatic push(input bit r, input logic [31:0] a, input logic [5:0] s,
                        input logic [7:0] be, input logic [63:0] d);
        e_row[n_e] = r; e_col[n_e] = !r; e_addr[n_e] = a;
        e_stat[n_e] = s; e_be[n_e] = be; e_dat[n_e] = d;
        n_e++;
    endtask

    task automatic model(input logic [31:0] a, input logic [1:0] sz, input bit wr, input logic [63:0] wd);
        bit hit;
        int bb, nb, beats, nby;
        logic [25:0] diff;
        n_e = 0;
        diff = a[31:6] ^ m_tag;
        hit = m_vld && (m_ps != 4'd8) && ((diff >> (m_lsb(m_ps) - 6)) == 0);
        if (!hit) begin
            push(1, a, wr ? 6'b000001 : 6'b000000, 8'h00, 64'h0);
            m_ps = strap_page; m_sh = strap_shift; m_bw = strap_bus; m_ct = strap_timing;
            m_vld = 1; m_tag = a[31:6];
        end
        bb = 1 << m_bw; nb = 1 << sz;
        beats = (nb > bb) ? nb / bb : 1;
        nby = (nb < bb) ? nb : bb;
        for (int b = 0; b < beats; b++) begin
            logic [31:0] ba;
            logic [7:0]  be;
            logic [63:0] dd;
            ba = a + 32'(b * bb);
            if (b > 0 && m_ps == 4'd8) begin
                push(1, ba, wr ? 6'b000001 : 6'b000000, 8'h00, 64'h0);
                m_tag = ba[31:6];
            end
            be = 0; dd = 0;
            for (int i = 0; i < nby; i++) begin
                logic [31:0] ra;
                int lane, src;
                ra = ba + 32'(i);
                lane = big_endian ? 7 - int'(ra % 32'(bb)) : int'(ra % 32'(bb));
                src = int'(ra % 32'(nb));
                be[lane] = 1'b1;
                if (wr) dd[8*lane +: 8] = wd[8*src +: 8];
            end
            for (int c = 0; c < m_cyc(m_ct); c++)
                push(0, m_colmap(ba, m_sh), 6'b011111, be, dd);
        end
    endtask

    task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                        input logic [63:0] wd, input bit poke);
        int ng;
        string tb;
        model(a, sz, wr, wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ng = 0; g_rows = 0; g_cols = 0;
        tb = big_endian ? "R9" : "R8";
        while (!req_ready && ng < 64) begin
            if (mem_row) g_rows++;
            if (mem_col) g_cols++;
            if (ng < n_e) begin
                chk(mem_row == e_row[ng], e_row[ng] ? "R4 row expected" : "R3 hit expected",
                    64'(mem_row), 64'(e_row[ng]));
                chk(mem_col == e_col[ng], "R7 column phase", 64'(mem_col), 64'(e_col[ng]));
                chk(mem_addr == e_addr[ng], e_row[ng] ? "R2 row address" : "R6 column address",
                    64'(mem_addr), 64'(e_addr[ng]));
                chk(mem_status == e_stat[ng], "R2 status", 64'(mem_status), 64'(e_stat[ng]));
                chk(mem_be == e_be[ng], {tb, " strobes"}, 64'(mem_be), 64'(e_be[ng]));
                chk(mem_wdata == e_dat[ng], {tb, " lane data"}, mem_wdata, e_dat[ng]);
            end
            if (poke && ng == 0) begin
                req_valid = 1'b1; req_addr = ~a; req_write = !wr;
            end
            @(negedge clk);
            req_valid = 1'b0;
            ng++;
        end
        chk(ng == n_e, "R10 transfer length", 64'(ng), 64'(n_e));
        if (poke) begin
            @(negedge clk);
            chk(!mem_row && !mem_col && req_ready, "R12 busy request ignored",
                64'({mem_row, mem_col, req_ready}), 64'b001);
        end
    endtask

    task automatic straps(input logic [3:0] p, input logic [2:0] s, input logic [1:0] b, input logic [2:0] t);
        strap_page = p; strap_shift = s; strap_bus = b; strap_timing = t;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] bases [0:3];
        void'($urandom(32'd90210));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 1);
        chk(!mem_row && !mem_col, "R1 strobes", 64'({mem_row, mem_col}), 0);
        chk(mem_status == 6'b011111, "R1 status", 64'(mem_status), 64'h1f);
        chk(mem_be == 0 && mem_addr == 0 && mem_wdata == 0, "R1 outputs", 64'(mem_be), 0);

        // R2 first access takes a row
        straps(4'd0, 3'd0, 2'd3, 3'd4);
        xfer(32'h1234_5600, 2'd3, 0, 64'h0, 0);
        chk(g_rows == 1, "R2 first access row", 64'(g_rows), 1);
        // R3 hit inside 64-byte page
        xfer(32'h1234_5608, 2'd3, 1, 64'h8877_6655_4433_2211, 0);
        chk(g_rows == 0, "R3 page hit", 64'(g_rows), 0);
        // R4 miss, latches 1K page size
        straps(4'd4, 3'd0, 2'd3, 3'd4);
        xfer(32'h1234_5640, 2'd3, 0, 64'h0, 0);
        chk(g_rows == 1, "R4 page miss", 64'(g_rows), 1);
        xfer(32'h1234_57C0, 2'd2, 1, 64'hAABB_CCDD, 0);
        chk(g_rows == 0, "R3 hit 1K page", 64'(g_rows), 0);
        // R11 strap changes before a hit have no effect
        straps(4'd8, 3'd7, 2'd0, 3'd7);
        xfer(32'h1234_5400, 2'd3, 1, 64'h0102_0304_0506_0708, 0);
        chk(g_rows == 0 && g_cols == 1, "R11 straps ignored on hit", 64'(g_cols), 1);
        // R5 page mode off: row before every beat
        straps(4'd8, 3'd2, 2'd1, 3'd6);
        xfer(32'h2000_0000, 2'd3, 1, 64'hF0E1_D2C3_B4A5_9687, 0);
        chk(g_rows == 4 && g_cols == 8, "R5 row per beat", 64'({g_rows, g_cols}), 64'({32'd4, 32'd8}));
        xfer(32'h2000_0000, 2'd0, 0, 64'h0, 0);
        chk(g_rows == 1, "R5 repeat address still rows", 64'(g_rows), 1);
        // R10/R7/R9 byte bus, 3-cycle columns, big-endian write
        big_endian = 1'b1;
        straps(4'd0, 3'd3, 2'd0, 3'd7);
        xfer(32'h3000_0004, 2'd2, 1, 64'h0000_0000_A1B2_C3D4, 0);
        chk(g_cols == 12, "R10 three-cycle columns", 64'(g_cols), 12);
        // R12 request during busy ignored
        big_endian = 1'b0;
        straps(4'd9, 3'd1, 2'd2, 3'd5);
        xfer(32'h4000_0000, 2'd3, 1, 64'h1111_2222_3333_4444, 1);

        bases[0] = 32'h0001_0000; bases[1] = 32'h0001_0400;
        bases[2] = 32'h00F0_0000; bases[3] = 32'h8000_0000;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            logic [1:0]  sz;
            sz = 2'($urandom_range(0, 3));
            a = bases[$urandom_range(0, 3)] + ($urandom & 32'h3FF);
            if ($urandom_range(0, 9) == 0) a = $urandom;
            a = a & ~((32'd1 << sz) - 1);
            big_endian = 1'($urandom);
            straps(4'($urandom), 3'($urandom), 2'($urandom), 3'($urandom));
            xfer(a, sz, 1'($urandom), {$urandom, $urandom}, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule